// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control unit and datapath of a small accumulator processor whose instructions and data share a single memory. Each instruction goes through a fixed series of one-clock register transfers. The program counter is copied into the address register. A read is issued. The returned word lands in the data register and then moves into the instruction register. The instruction is then split into an operation code and an operand. The operand goes either to the address register, when it names a memory location, or into the data register, when it is literal data. Results of the arithmetic and logic unit are written to the accumulator, and a zero flag tracks the accumulator.

The memory port is split into an output-only address, separate read and write strobes, an outgoing write word and an incoming read word. The memory has one cycle of read latency. The port never carries a fetch and a data access in the same cycle. The instruction word holds a 4-bit operation code in bits 15:12 and a mode flag in bit 11, where 1 means literal data and 0 means an address. Bits 10:0 hold the operand. The data width is a parameter, and the operand and address width is derived from it.

Top module: `acc_cpu_seq`

## Requirements
- R1: A synchronous active-high reset sets the program counter and accumulator to zero, sets the zero flag to 1, deasserts both memory strobes and leaves the halted output low.
- R2: The first clock after reset is released issues a read at address 0. Every instruction is fetched with a read at the current program counter, and the counter then advances by one. After a halt it therefore holds the halt instruction's address plus one.
- R3: With the mode flag (bit 11) at 1, a load or arithmetic/logic instruction uses its 11-bit operand, zero-extended, as data. It makes no data access and takes 5 clocks.
- R4: With the mode flag at 0, a load or arithmetic/logic instruction reads its operand from the memory address it names. It takes 7 clocks.
- R5: STORE (code 1) writes the accumulator to the operand address whatever the mode flag holds, and takes 5 clocks.
- R6: The codes have these effects on the accumulator: LOAD (0) copies the operand value; ADD (2) and SUB (3) add and subtract modulo 2^16; AND (4), OR (5) and XOR (6) combine bitwise.
- R7: NOT (7) inverts the accumulator. SHL (8) shifts it left by one with a zero fill. SHR (9) shifts it right by one, with a zero fill under the default parameter. Each takes 5 clocks.
- R8: JMP (code 10) loads the operand into the program counter. JZ (code 11) does so only when the zero flag is 1 and otherwise continues in sequence. Each takes 5 clocks.
- R9: HALT (code 15) stops the sequencer 4 clocks after its fetch starts and raises halted. From then until reset, no strobe is driven and the program counter and accumulator hold.
- R10: Codes 12, 13 and 14 change neither the accumulator nor the instruction order, and take 5 clocks.
- R11: The read and write strobes are never asserted together. A write is followed by a clock with no memory access.
- R12: The zero flag equals 1 exactly when the accumulator is zero, at every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns on the next clock |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Word to write (the accumulator) |
| mem_rdata | input | 16 | Word returned by memory |
| acc_val | output | 16 | Accumulator |
| zero_flag | output | 1 | Accumulator-is-zero flag |
| pc_val | output | 11 | Program counter |
| halted | output | 1 | Sequencer stopped by HALT |

## Verification
The assertions rely on the memory returning the addressed word exactly one clock after a read strobe, and on the memory having no side effects beyond storing written words. The bench memory is a plain synchronous array that behaves exactly this way. Random programs place their code in low memory and their data in a separate region above, so no instruction is ever overwritten. Every program ends in a HALT. Jump operands appear only in directed programs, where their targets are chosen so that each program reaches its HALT.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

   typedef enum logic [3:0] {
      OP_LOAD = 4'd0,  OP_STORE = 4'd1,  OP_ADD = 4'd2,  OP_SUB = 4'd3,
      OP_AND  = 4'd4,  OP_OR    = 4'd5,  OP_XOR = 4'd6,  OP_NOT = 4'd7,
      OP_SHL  = 4'd8,  OP_SHR   = 4'd9,  OP_JMP = 4'd10, OP_JZ  = 4'd11,
      OP_RSV0 = 4'd12, OP_RSV1  = 4'd13, OP_RSV2 = 4'd14, OP_HALT = 4'd15
   } opcode_e;

   typedef enum logic [2:0] {
      S_FETCH_ADDR, S_FETCH_READ, S_FETCH_LOAD, S_DECODE,
      S_EXEC_ADDR,  S_EXEC_MEM,   S_EXEC_WB,    S_HALT
   } seq_state_e;

   // operations whose operand may come from memory
   function automatic logic uses_operand(opcode_e op);
      return op inside {OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR};
   endfunction

endpackage

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
   import acc_cpu_pkg::*;
#(
   parameter int DW        = 16,
   parameter bit ARITH_SHR = 1'b0
) (
   input  opcode_e          op,
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    b,
   output logic [DW-1:0]    y,
   output logic             we
);

   logic [DW-1:0] shr_res;

   generate
      if (ARITH_SHR) begin : g_shr_arith
         assign shr_res = {a[DW-1], a[DW-1:1]};
      end else begin : g_shr_logic
         assign shr_res = {1'b0, a[DW-1:1]};
      end
   endgenerate

   always_comb begin
      y  = a;
      we = 1'b1;
      unique case (op)
         OP_LOAD: y = b;
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOT:  y = ~a;
         OP_SHL:  y = {a[DW-2:0], 1'b0};
         OP_SHR:  y = shr_res;
         default: we = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_seq_ctrl.sv
`timescale 1ns/1ps
module acc_seq_ctrl
   import acc_cpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  opcode_e    dec_op,
   input  logic       dec_imm,
   input  opcode_e    exe_op,
   output seq_state_e state
);

   seq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         S_FETCH_ADDR: nxt = S_FETCH_READ;
         S_FETCH_READ: nxt = S_FETCH_LOAD;
         S_FETCH_LOAD: nxt = S_DECODE;
         S_DECODE: begin
            if (dec_op == OP_HALT)
               nxt = S_HALT;
            else if (dec_op == OP_STORE || (uses_operand(dec_op) && !dec_imm))
               nxt = S_EXEC_ADDR;
            else
               nxt = S_EXEC_WB;
         end
         S_EXEC_ADDR:  nxt = (exe_op == OP_STORE) ? S_FETCH_ADDR : S_EXEC_MEM;
         S_EXEC_MEM:   nxt = S_EXEC_WB;
         S_EXEC_WB:    nxt = S_FETCH_ADDR;
         S_HALT:       nxt = S_HALT;
         default:      nxt = S_FETCH_ADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= S_FETCH_ADDR;
      else     state <= nxt;
   end

   // R2
   fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_FETCH_READ) |=> (state == S_FETCH_LOAD));

   // R9
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_HALT) |=> (state == S_HALT));

endmodule

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq
   import acc_cpu_pkg::*;
#(
   parameter int DW        = 16,
   parameter bit ARITH_SHR = 1'b0,
   localparam int OPW      = 4,
   localparam int AW       = DW - OPW - 1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] acc_val,
   output logic          zero_flag,
   output logic [AW-1:0] pc_val,
   output logic          halted
);

   generate
      if (DW < 8) begin : g_bad_width
         $error("acc_cpu_seq: DW must be at least 8");
      end
   endgenerate

   localparam int MODE_BIT = AW;

   logic [AW-1:0] pc_q, mar_q;
   logic [DW-1:0] mdr_q, cir_q, acc_q;
   logic          zero_q;
   seq_state_e    state;
   opcode_e       dec_op, exe_op;
   logic          dec_imm;
   logic [DW-1:0] alu_y;
   logic          alu_we;

   assign dec_op  = opcode_e'(mdr_q[DW-1 -: OPW]);
   assign dec_imm = mdr_q[MODE_BIT];
   assign exe_op  = opcode_e'(cir_q[DW-1 -: OPW]);

   acc_seq_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .dec_op  (dec_op),
      .dec_imm (dec_imm),
      .exe_op  (exe_op),
      .state   (state)
   );

   acc_alu #(.DW(DW), .ARITH_SHR(ARITH_SHR)) u_alu (
      .op (exe_op),
      .a  (acc_q),
      .b  (mdr_q),
      .y  (alu_y),
      .we (alu_we)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         mar_q  <= '0;
         mdr_q  <= '0;
         cir_q  <= '0;
         acc_q  <= '0;
         zero_q <= 1'b1;
      end else begin
         unique case (state)
            S_FETCH_ADDR: mar_q <= pc_q;
            S_FETCH_READ: pc_q  <= pc_q + 1'b1;
            S_FETCH_LOAD: mdr_q <= mem_rdata;
            S_DECODE: begin
               cir_q <= mdr_q;
               if (dec_op == OP_STORE || (uses_operand(dec_op) && !dec_imm))
                  mar_q <= mdr_q[AW-1:0];
               else
                  mdr_q <= {{(DW-AW){1'b0}}, mdr_q[AW-1:0]};
            end
            S_EXEC_MEM: mdr_q <= mem_rdata;
            S_EXEC_WB: begin
               if (alu_we) begin
                  acc_q  <= alu_y;
                  zero_q <= (alu_y == '0);
               end
               if (exe_op == OP_JMP || (exe_op == OP_JZ && zero_q))
                  pc_q <= cir_q[AW-1:0];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      mem_rd = (state == S_FETCH_READ) || (state == S_EXEC_ADDR && exe_op != OP_STORE);
      mem_wr = (state == S_EXEC_ADDR) && (exe_op == OP_STORE);
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = acc_q;
   assign acc_val   = acc_q;
   assign zero_flag = zero_q;
   assign pc_val    = pc_q;
   assign halted    = (state == S_HALT);

   // R11
   rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R11
   store_gap_chk: assert property (@(posedge clk) disable iff (rst)
      mem_wr |=> (!mem_rd && !mem_wr));

   // R12
   zero_track_chk: assert property (@(posedge clk) disable iff (rst)
      zero_flag == (acc_val == '0));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_FETCH_READ) |=> (pc_val == $past(pc_val) + 1'b1));

   // R9
   halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && !mem_rd && !mem_wr && $stable(pc_val) && $stable(acc_val)));

endmodule

// File: tb/sim_acc_cpu_seq.sv
`timescale 1ns/1ps
module sim_acc_cpu_seq;
   localparam int DW = 16;
   localparam int AW = DW - 5;
   localparam int MW = 1 << AW;
   localparam int DBASE = 1024;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [AW-1:0] mem_addr, pc_val;
   logic          mem_rd, mem_wr, zero_flag, halted;
   logic [DW-1:0] mem_wdata, acc_val;
   logic [DW-1:0] mem_rdata = '0;

   acc_cpu_seq #(.DW(DW), .ARITH_SHR(1'b0)) u0 (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_val(acc_val),
      .zero_flag(zero_flag), .pc_val(pc_val), .halted(halted)
   );

   logic [DW-1:0] mem     [MW];
   logic [DW-1:0] ref_mem [MW];

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   int checks = 0, errors = 0;
   int overlap = 0, zbad = 0, hstrobe = 0;

   always @(negedge clk) begin
      if (!rst) begin
         if (mem_rd && mem_wr) overlap++;
         if (zero_flag != (acc_val == '0)) zbad++;
         if (halted && (mem_rd || mem_wr)) hstrobe++;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] enc(input int op, input bit imm, input int opd);
      logic [3:0]  o = op[3:0];
      logic [10:0] d = opd[10:0];
      return {o, imm, d};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < MW; i++) mem[i] = '0;
   endtask

   // Reference model of the instruction set, cycle counts from R3, R4, R5, R7, R8, R9, R10
   task automatic ref_run(output logic [DW-1:0] acc, output bit z,
                          output logic [AW-1:0] pc, output int cyc);
      logic [DW-1:0] w, v;
      logic [3:0]    op;
      logic          imm;
      logic [AW-1:0] opd;
      bit            memop;
      acc = '0; z = 1'b1; pc = '0; cyc = 0;
      for (int s = 0; s < 1000; s++) begin
         w = ref_mem[pc];
         pc = pc + 1'b1;
         op = w[15:12]; imm = w[11]; opd = w[10:0];
         v = imm ? {5'b0, opd} : ref_mem[opd];
         memop = (op == 0) || (op >= 2 && op <= 6);
         if (op == 4'd15) begin cyc += 4; break; end
         cyc += (memop && !imm) ? 7 : 5;
         case (op)
            4'd0:  acc = v;
            4'd1:  ref_mem[opd] = acc;
            4'd2:  acc = acc + v;
            4'd3:  acc = acc - v;
            4'd4:  acc = acc & v;
            4'd5:  acc = acc | v;
            4'd6:  acc = acc ^ v;
            4'd7:  acc = ~acc;
            4'd8:  acc = {acc[DW-2:0], 1'b0};
            4'd9:  acc = {1'b0, acc[DW-1:1]};
            4'd10: pc = opd;
            4'd11: if (z) pc = opd;
            default: ;
         endcase
         if (op <= 4'd9 && op != 4'd1) z = (acc == '0);
      end
   endtask

   task automatic run_prog(input string tag);
      logic [DW-1:0] e_acc, h_acc;
      bit            e_z;
      logic [AW-1:0] e_pc, h_pc;
      int            e_cyc, cyc, mism;
      for (int i = 0; i < MW; i++) ref_mem[i] = mem[i];
      ref_run(e_acc, e_z, e_pc, e_cyc);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(pc_val == 0 && acc_val == 0 && zero_flag && !mem_rd && !mem_wr && !halted,
          "R1", "reset state", {acc_val, 5'b0, pc_val}, 32'h0);
      rst = 1'b0;
      @(posedge clk); @(negedge clk);
      cyc = 1;
      // R2 first fetch at address 0
      chk(mem_rd && !mem_wr && mem_addr == 0, "R2", "first fetch address",
          {20'b0, mem_rd, mem_addr}, {20'b0, 1'b1, 11'h0});
      while (!halted && cyc < 20000) begin
         @(posedge clk); cyc++; @(negedge clk);
      end
      chk(acc_val == e_acc, tag, "accumulator", acc_val, e_acc);
      chk(zero_flag == e_z, "R12", "zero flag", zero_flag, e_z);
      chk(pc_val == e_pc, "R2", "program counter after halt", pc_val, e_pc);
      chk(cyc == e_cyc, "R3 R4", "clocks to halt", cyc, e_cyc);
      mism = 0;
      for (int i = DBASE; i < DBASE + 64; i++) if (mem[i] !== ref_mem[i]) mism++;
      chk(mism == 0, "R5", "data region mismatches", mism, 0);
      h_pc = pc_val; h_acc = acc_val;
      repeat (6) @(negedge clk);
      // R9 freeze after halt
      chk(halted && pc_val == h_pc && acc_val == h_acc, "R9", "state held after halt",
          {acc_val, 5'b0, pc_val}, {h_acc, 5'b0, h_pc});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R9 watchdog expired: actual 1 expected 0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int ops [11] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 12};
      void'($urandom(32'd2024));

      // R8 JMP skips an instruction
      clear_mem();
      mem[0] = enc(0, 1, 5); mem[1] = enc(10, 1, 3); mem[2] = enc(0, 1, 9);
      mem[3] = enc(2, 1, 1); mem[4] = enc(15, 0, 0);
      run_prog("R8 jmp");
      chk(acc_val == 16'd6, "R8", "jump target result", acc_val, 16'd6);

      // R8 JZ taken
      clear_mem();
      mem[0] = enc(0, 1, 0); mem[1] = enc(11, 1, 3); mem[2] = enc(0, 1, 7);
      mem[3] = enc(6, 1, 2); mem[4] = enc(15, 0, 0);
      run_prog("R8 jz taken");
      chk(acc_val == 16'd2, "R8", "jz taken result", acc_val, 16'd2);

      // R8 JZ not taken
      clear_mem();
      mem[0] = enc(0, 1, 1); mem[1] = enc(11, 1, 3); mem[2] = enc(0, 1, 7);
      mem[3] = enc(6, 1, 2); mem[4] = enc(15, 0, 0);
      run_prog("R8 jz not taken");
      chk(acc_val == 16'd5, "R8", "jz fall-through result", acc_val, 16'd5);

      // R10 reserved codes are no-ops
      clear_mem();
      mem[0] = enc(0, 1, 3); mem[1] = enc(12, 1, 7); mem[2] = enc(13, 0, 9);
      mem[3] = enc(14, 1, 1); mem[4] = enc(15, 0, 0);
      run_prog("R10 reserved");
      chk(acc_val == 16'd3 && pc_val == 11'd5, "R10", "reserved codes no effect",
          {acc_val, 5'b0, pc_val}, {16'd3, 5'b0, 11'd5});

      // R6 R7 underflow, shifts, invert
      clear_mem();
      mem[0] = enc(0, 1, 0); mem[1] = enc(3, 1, 1); mem[2] = enc(9, 0, 0);
      mem[3] = enc(8, 0, 0); mem[4] = enc(7, 0, 0); mem[5] = enc(15, 0, 0);
      run_prog("R7 shifts");
      chk(acc_val == 16'h0001, "R7", "sub-shr-shl-not chain", acc_val, 16'h0001);

      // R5 store with mode flag set still addresses memory; R4 reload by address
      clear_mem();
      mem[0] = enc(0, 1, 16'h55); mem[1] = enc(1, 1, DBASE + 6); mem[2] = enc(0, 1, 0);
      mem[3] = enc(0, 0, DBASE + 6); mem[4] = enc(15, 0, 0);
      run_prog("R5 store");
      chk(mem[DBASE + 6] == 16'h55 && acc_val == 16'h55, "R5", "stored then reloaded",
          mem[DBASE + 6], 16'h55);

      // R6 random programs mixing literal and address operands
      for (int t = 0; t < 40; t++) begin
         int n;
         clear_mem();
         n = 4 + int'($urandom % 16);
         for (int k = 0; k < n; k++) begin
            int  op  = ops[$urandom % 11];
            bit  imm = 1'($urandom % 2);
            int  opd = (imm && op != 1) ? int'($urandom % MW) : DBASE + int'($urandom % 32);
            mem[k] = enc(op, imm, opd);
         end
         mem[n] = enc(15, 0, 0);
         for (int i = 0; i < 32; i++) mem[DBASE + i] = DW'($urandom);
         run_prog("R6");
      end

      chk(overlap == 0, "R11", "cycles with read and write together", overlap, 0);
      chk(zbad == 0, "R12", "clocks with zero flag out of step", zbad, 0);
      chk(hstrobe == 0, "R9", "strobes while halted", hstrobe, 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule